// File: doc/BRIEF.md
# Two-Layer Stub Coincidence Finder

Every bunch crossing, this block receives a set of zero-suppressed cluster positions from a pixel layer and from a strip layer, in parallel. For each pixel cluster it looks for a strip cluster whose position, after an alignment offset is removed, lies within a programmable signed window. A pixel cluster with a match becomes a stub that carries the pixel position, the pixel row and the bend, which is the corrected strip-minus-pixel offset. Stubs go out as a bounded list in fixed output slots. A flag is raised when more stubs were found than the list can hold.

Positions use half-strip units, 8 bits wide. The window half-width can be set from 0 to 7. The alignment offset is a signed value that is applied to the whole crossing. The block is fully pipelined and takes a new crossing on every clock. Each result appears a fixed two cycles after its inputs.

Top module: `stub_finder`

## Requirements
- R1: The bend of a pair is strip position − pixel position − offset, with the offset read as two's complement. It is output as a signed two's-complement value of WIN_W+1 bits (4 bits by default).
- R2: A pair is accepted only when |bend| ≤ win, with win an unsigned value from 0 to 2^WIN_W−1 (0 to 7 by default).
- R3: Each pixel cluster yields at most one stub. Among the strips that pass the window it takes the one with the smallest |bend|, and on a tie the lowest strip slot index wins.
- R4: A pixel slot whose pix_vld bit is 0, or a strip slot whose str_vld bit is 0, takes no part in any pair.
- R5: Stubs fill output slots 0, 1, 2 and onward without gaps, in ascending pixel slot order, so lower slots have priority. Unused slots have stub_vld = 0 and zero data.
- R6: At most MAX_STUBS (default 5) stubs are output per crossing. stub_cnt gives the number output. stub_trunc is 1 exactly when more than MAX_STUBS pixel clusters had a match.
- R7: The outputs for a crossing appear 2 clock cycles after its inputs are presented with in_valid = 1. out_vld follows in_valid with the same delay. A crossing presented with in_valid = 0 yields no stubs and no flag.
- R8: After reset, all outputs are zero.
- R9: Each stub carries the position and the row of its pixel cluster unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crossing clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | The inputs of this cycle form a crossing |
| win | input | WIN_W | Window half-width |
| ofs | input | OFS_W | Signed alignment offset subtracted from the bend |
| pix_vld | input | NPIX | Per-slot pixel cluster present |
| pix_pos | input | NPIX*POS_W | Pixel cluster positions, slot i at bits [i*POS_W +: POS_W] |
| pix_row | input | NPIX*ROW_W | Pixel cluster rows, slot i at bits [i*ROW_W +: ROW_W] |
| str_vld | input | NSTR | Per-slot strip cluster present |
| str_pos | input | NSTR*POS_W | Strip cluster positions, slot j at bits [j*POS_W +: POS_W] |
| out_vld | output | 1 | Output crossing valid |
| stub_vld | output | MAX_STUBS | Per-slot stub present |
| stub_pos | output | MAX_STUBS*POS_W | Stub pixel positions |
| stub_row | output | MAX_STUBS*ROW_W | Stub pixel rows |
| stub_bend | output | MAX_STUBS*(WIN_W+1) | Signed stub bends |
| stub_cnt | output | $clog2(MAX_STUBS+1) | Number of stubs output |
| stub_trunc | output | 1 | More matches were found than were output |

## Verification
The bench builds the block with 8 pixel slots, 4 strip slots, 5 output slots, 8-bit positions, a 3-bit window and a 4-bit offset. With these values the bench sweeps every window value against offsets from −3 to +3 and bends from −10 to +10, in every pixel and strip slot. This covers the exact acceptance edges and the sign of the bend. Since there are more pixel slots than output slots, truncation can be reached, and the bench tests both the exact-fit case and the overflow case. Positions at 0 and 255 test the arithmetic range. The final stage is a long stream of random masks and clustered positions, applied back to back, which tests nearest-strip ties and the two-cycle latency against an arithmetic model.

// File: rtl/stub_pkg.sv
package stub_pkg;
   // width of a count able to hold 0..n
   function automatic int cnt_width(input int n);
      return (n < 1) ? 1 : $clog2(n + 1);
   endfunction
endpackage

// File: rtl/stub_match.sv
module stub_match #(
   parameter int NSTR   = 8,
   parameter int POS_W  = 8,
   parameter int OFS_W  = 4,
   parameter int WIN_W  = 3,
   parameter int BEND_W = WIN_W + 1
) (
   input  logic [POS_W-1:0]      pix_pos,
   input  logic                  pix_ok,
   input  logic [NSTR*POS_W-1:0] str_pos,
   input  logic [NSTR-1:0]       str_vld,
   input  logic [WIN_W-1:0]      win,
   input  logic [OFS_W-1:0]      ofs,
   output logic                  hit,
   output logic [BEND_W-1:0]     bend
);
   localparam int DW = POS_W + 2;

   logic signed [DW-1:0] ofs_x, win_x, diff, mag, best_mag, best_d;
   logic                 found;

   always_comb begin
      ofs_x    = {{(DW-OFS_W){ofs[OFS_W-1]}}, ofs};
      win_x    = {{(DW-WIN_W){1'b0}}, win};
      found    = 1'b0;
      best_mag = '0;
      best_d   = '0;
      diff     = '0;
      mag      = '0;
      for (int j = 0; j < NSTR; j++) begin
         if (str_vld[j]) begin
            diff = $signed({2'b00, str_pos[j*POS_W +: POS_W]})
                 - $signed({2'b00, pix_pos}) - ofs_x;
            mag  = diff[DW-1] ? -diff : diff;
            if (mag <= win_x && (!found || mag < best_mag)) begin
               found    = 1'b1;
               best_mag = mag;
               best_d   = diff;
            end
         end
      end
      hit  = pix_ok & found;
      bend = best_d[BEND_W-1:0];
   end
endmodule

// File: rtl/stub_select.sv
module stub_select #(
   parameter int NPIX      = 8,
   parameter int MAX_STUBS = 5,
   parameter int POS_W     = 8,
   parameter int ROW_W     = 4,
   parameter int BEND_W    = 4,
   parameter int CNT_W     = 3
) (
   input  logic [NPIX-1:0]             c_hit,
   input  logic [NPIX*POS_W-1:0]       c_pos,
   input  logic [NPIX*ROW_W-1:0]       c_row,
   input  logic [NPIX*BEND_W-1:0]      c_bend,
   output logic [MAX_STUBS-1:0]        o_vld,
   output logic [MAX_STUBS*POS_W-1:0]  o_pos,
   output logic [MAX_STUBS*ROW_W-1:0]  o_row,
   output logic [MAX_STUBS*BEND_W-1:0] o_bend,
   output logic [CNT_W-1:0]            o_cnt,
   output logic                        o_trunc
);
   int n;

   always_comb begin
      o_vld  = '0;
      o_pos  = '0;
      o_row  = '0;
      o_bend = '0;
      n      = 0;
      for (int i = 0; i < NPIX; i++) begin
         if (c_hit[i]) begin
            if (n < MAX_STUBS) begin
               o_vld[n]                   = 1'b1;
               o_pos[n*POS_W +: POS_W]    = c_pos[i*POS_W +: POS_W];
               o_row[n*ROW_W +: ROW_W]    = c_row[i*ROW_W +: ROW_W];
               o_bend[n*BEND_W +: BEND_W] = c_bend[i*BEND_W +: BEND_W];
            end
            n = n + 1;
         end
      end
      o_trunc = (n > MAX_STUBS);
      o_cnt   = o_trunc ? CNT_W'(MAX_STUBS) : CNT_W'(n);
   end
endmodule

// File: rtl/stub_finder.sv
module stub_finder #(
   parameter int NPIX      = 8,
   parameter int NSTR      = 8,
   parameter int MAX_STUBS = 5,
   parameter int POS_W     = 8,
   parameter int ROW_W     = 4,
   parameter int WIN_W     = 3,
   parameter int OFS_W     = 4,
   localparam int BEND_W   = WIN_W + 1,
   localparam int CNT_W    = stub_pkg::cnt_width(MAX_STUBS)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        in_valid,
   input  logic [WIN_W-1:0]            win,
   input  logic [OFS_W-1:0]            ofs,
   input  logic [NPIX-1:0]             pix_vld,
   input  logic [NPIX*POS_W-1:0]       pix_pos,
   input  logic [NPIX*ROW_W-1:0]       pix_row,
   input  logic [NSTR-1:0]             str_vld,
   input  logic [NSTR*POS_W-1:0]       str_pos,
   output logic                        out_vld,
   output logic [MAX_STUBS-1:0]        stub_vld,
   output logic [MAX_STUBS*POS_W-1:0]  stub_pos,
   output logic [MAX_STUBS*ROW_W-1:0]  stub_row,
   output logic [MAX_STUBS*BEND_W-1:0] stub_bend,
   output logic [CNT_W-1:0]            stub_cnt,
   output logic                        stub_trunc
);
   // elaboration-time parameter checks
   if (MAX_STUBS < 1 || MAX_STUBS > NPIX) begin : g_bad_max
      $error("stub_finder: MAX_STUBS must lie in 1..NPIX");
   end
   if (NSTR < 1) begin : g_bad_nstr
      $error("stub_finder: NSTR must be at least 1");
   end
   if (OFS_W < 1 || OFS_W > POS_W) begin : g_bad_ofs
      $error("stub_finder: OFS_W must lie in 1..POS_W");
   end
   if (WIN_W < 1 || WIN_W >= POS_W) begin : g_bad_win
      $error("stub_finder: WIN_W must lie in 1..POS_W-1");
   end

   // stage 0: window match per pixel slot
   logic [NPIX-1:0]        m_hit;
   logic [NPIX*BEND_W-1:0] m_bend;

   for (genvar i = 0; i < NPIX; i++) begin : g_match
      stub_match #(
         .NSTR  (NSTR),
         .POS_W (POS_W),
         .OFS_W (OFS_W),
         .WIN_W (WIN_W),
         .BEND_W(BEND_W)
      ) u_match (
         .pix_pos(pix_pos[i*POS_W +: POS_W]),
         .pix_ok (pix_vld[i] & in_valid),
         .str_pos(str_pos),
         .str_vld(str_vld),
         .win    (win),
         .ofs    (ofs),
         .hit    (m_hit[i]),
         .bend   (m_bend[i*BEND_W +: BEND_W])
      );
   end

   // stage 1 registers
   logic                   s1_vld;
   logic [NPIX-1:0]        s1_hit;
   logic [NPIX*POS_W-1:0]  s1_pos;
   logic [NPIX*ROW_W-1:0]  s1_row;
   logic [NPIX*BEND_W-1:0] s1_bend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_vld  <= 1'b0;
         s1_hit  <= '0;
         s1_pos  <= '0;
         s1_row  <= '0;
         s1_bend <= '0;
      end else begin
         s1_vld  <= in_valid;
         s1_hit  <= m_hit;
         s1_pos  <= pix_pos;
         s1_row  <= pix_row;
         s1_bend <= m_bend;
      end
   end

   // stage 1: priority compaction into output slots
   logic [MAX_STUBS-1:0]        c_vld;
   logic [MAX_STUBS*POS_W-1:0]  c_pos;
   logic [MAX_STUBS*ROW_W-1:0]  c_row;
   logic [MAX_STUBS*BEND_W-1:0] c_bend;
   logic [CNT_W-1:0]            c_cnt;
   logic                        c_trunc;

   stub_select #(
      .NPIX     (NPIX),
      .MAX_STUBS(MAX_STUBS),
      .POS_W    (POS_W),
      .ROW_W    (ROW_W),
      .BEND_W   (BEND_W),
      .CNT_W    (CNT_W)
   ) u_select (
      .c_hit  (s1_hit),
      .c_pos  (s1_pos),
      .c_row  (s1_row),
      .c_bend (s1_bend),
      .o_vld  (c_vld),
      .o_pos  (c_pos),
      .o_row  (c_row),
      .o_bend (c_bend),
      .o_cnt  (c_cnt),
      .o_trunc(c_trunc)
   );

   // stage 2 output registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_vld    <= 1'b0;
         stub_vld   <= '0;
         stub_pos   <= '0;
         stub_row   <= '0;
         stub_bend  <= '0;
         stub_cnt   <= '0;
         stub_trunc <= 1'b0;
      end else begin
         out_vld    <= s1_vld;
         stub_vld   <= c_vld;
         stub_pos   <= c_pos;
         stub_row   <= c_row;
         stub_bend  <= c_bend;
         stub_cnt   <= c_cnt;
         stub_trunc <= c_trunc;
      end
   end
endmodule

// File: rtl/stub_finder_chk.sv
module stub_finder_chk #(
   parameter int MAX_STUBS = 5,
   parameter int WIN_W     = 3,
   parameter int BEND_W    = 4,
   parameter int CNT_W     = 3
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        in_valid,
   input logic [WIN_W-1:0]            win,
   input logic                        out_vld,
   input logic [MAX_STUBS-1:0]        stub_vld,
   input logic [MAX_STUBS*BEND_W-1:0] stub_bend,
   input logic [CNT_W-1:0]            stub_cnt,
   input logic                        stub_trunc
);
   logic             v1, v2;
   logic [WIN_W-1:0] w1, w2;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v1 <= 1'b0; v2 <= 1'b0; w1 <= '0; w2 <= '0;
      end else begin
         v1 <= in_valid; v2 <= v1; w1 <= win; w2 <= w1;
      end
   end

   a_r6_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      int'(stub_cnt) <= MAX_STUBS);

   a_r5_count_match: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(stub_vld) == int'(stub_cnt));

   a_r6_trunc_full: assert property (@(posedge clk) disable iff (!rst_n)
      stub_trunc |-> int'(stub_cnt) == MAX_STUBS);

   a_r7_valid_delay: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld == v2);

   a_r7_idle_empty: assert property (@(posedge clk) disable iff (!rst_n)
      !out_vld |-> (stub_vld == '0 && !stub_trunc));

   for (genvar k = 0; k < MAX_STUBS; k++) begin : g_slot
      a_r2_bend_window: assert property (@(posedge clk) disable iff (!rst_n)
         stub_vld[k] |->
            (($signed(stub_bend[k*BEND_W +: BEND_W]) < 0)
               ? -int'($signed(stub_bend[k*BEND_W +: BEND_W]))
               :  int'($signed(stub_bend[k*BEND_W +: BEND_W]))) <= int'(w2));
      if (k > 0) begin : g_gap
         a_r5_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
            stub_vld[k] |-> stub_vld[k-1]);
      end
   end
endmodule

bind stub_finder stub_finder_chk #(
   .MAX_STUBS(MAX_STUBS),
   .WIN_W    (WIN_W),
   .BEND_W   (BEND_W),
   .CNT_W    (CNT_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .win       (win),
   .out_vld   (out_vld),
   .stub_vld  (stub_vld),
   .stub_bend (stub_bend),
   .stub_cnt  (stub_cnt),
   .stub_trunc(stub_trunc)
);

// File: tb/stub_finder_tb_top.sv
module stub_finder_tb_top;
   localparam int NP = 8, NS = 4, MX = 5, PW = 8, RW = 4, WW = 3, OW = 4;
   localparam int BW = WW + 1, CW = 3;

   typedef struct packed {
      logic             ov;
      logic [MX-1:0]    vld;
      logic [MX*PW-1:0] pos;
      logic [MX*RW-1:0] row;
      logic [MX*BW-1:0] bend;
      logic [CW-1:0]    cnt;
      logic             trunc;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic             in_valid;
   logic [WW-1:0]    win;
   logic [OW-1:0]    ofs;
   logic [NP-1:0]    pix_vld;
   logic [NP*PW-1:0] pix_pos;
   logic [NP*RW-1:0] pix_row;
   logic [NS-1:0]    str_vld;
   logic [NS*PW-1:0] str_pos;
   logic             out_vld;
   logic [MX-1:0]    stub_vld;
   logic [MX*PW-1:0] stub_pos;
   logic [MX*RW-1:0] stub_row;
   logic [MX*BW-1:0] stub_bend;
   logic [CW-1:0]    stub_cnt;
   logic             stub_trunc;

   stub_finder #(
      .NPIX(NP), .NSTR(NS), .MAX_STUBS(MX), .POS_W(PW),
      .ROW_W(RW), .WIN_W(WW), .OFS_W(OW)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .win(win), .ofs(ofs),
      .pix_vld(pix_vld), .pix_pos(pix_pos), .pix_row(pix_row),
      .str_vld(str_vld), .str_pos(str_pos), .out_vld(out_vld),
      .stub_vld(stub_vld), .stub_pos(stub_pos), .stub_row(stub_row),
      .stub_bend(stub_bend), .stub_cnt(stub_cnt), .stub_trunc(stub_trunc)
   );

   // staging values for the next crossing
   logic          n_iv;
   int            n_win, n_ofs;
   logic [NP-1:0] n_pv;
   int            n_pp [NP];
   int            n_pr [NP];
   logic [NS-1:0] n_sv;
   int            n_sp [NS];

   int   total = 0, bad = 0;
   exp_t q0 = '0, q1 = '0;

   function automatic exp_t model();
      exp_t e = '0;
      int   n = 0;
      e.ov = n_iv;
      if (!n_iv) return e;
      for (int i = 0; i < NP; i++) begin
         bit found = 0;
         int bd = 0, bm = 0;
         if (!n_pv[i]) continue;                 // R4
         for (int j = 0; j < NS; j++) begin
            int d, m;
            if (!n_sv[j]) continue;              // R4
            d = n_sp[j] - n_pp[i] - n_ofs;       // R1
            m = (d < 0) ? -d : d;
            if (m <= n_win && (!found || m < bm)) begin  // R2, R3
               found = 1; bd = d; bm = m;
            end
         end
         if (found) begin
            if (n < MX) begin                    // R5, R9
               e.vld[n]           = 1'b1;
               e.pos[n*PW +: PW]  = PW'(n_pp[i]);
               e.row[n*RW +: RW]  = RW'(n_pr[i]);
               e.bend[n*BW +: BW] = BW'(bd);
            end
            n++;
         end
      end
      e.trunc = (n > MX);                        // R6
      e.cnt   = CW'((n > MX) ? MX : n);
      return e;
   endfunction

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s t=%0t actual=%0h expected=%0h", tag, $time, act, exp);
      end
   endtask

   task automatic compare(input exp_t e);
      chk("R7 out_vld",     64'(out_vld),    64'(e.ov));
      chk("R5 stub_vld",    64'(stub_vld),   64'(e.vld));
      chk("R9 stub_pos",    64'(stub_pos),   64'(e.pos));
      chk("R9 stub_row",    64'(stub_row),   64'(e.row));
      chk("R1 stub_bend",   64'(stub_bend),  64'(e.bend));
      chk("R6 stub_cnt",    64'(stub_cnt),   64'(e.cnt));
      chk("R6 stub_trunc",  64'(stub_trunc), 64'(e.trunc));
   endtask

   task automatic apply();
      in_valid = n_iv;
      win      = WW'(n_win);
      ofs      = OW'(n_ofs);
      pix_vld  = n_pv;
      str_vld  = n_sv;
      for (int i = 0; i < NP; i++) begin
         pix_pos[i*PW +: PW] = PW'(n_pp[i]);
         pix_row[i*RW +: RW] = RW'(n_pr[i]);
      end
      for (int j = 0; j < NS; j++) str_pos[j*PW +: PW] = PW'(n_sp[j]);
   endtask

   // one crossing: check the result of two crossings ago (R7), then drive
   task automatic tick();
      @(negedge clk);
      compare(q1);
      q1 = q0;
      apply();
      q0 = model();
   endtask

   task automatic clear();
      n_iv = 1'b1; n_win = 0; n_ofs = 0; n_pv = '0; n_sv = '0;
      for (int i = 0; i < NP; i++) begin n_pp[i] = 0; n_pr[i] = 0; end
      for (int j = 0; j < NS; j++) n_sp[j] = 0;
   endtask

   initial begin
      #(4 * 150000);
      bad++; total++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      clear();
      n_iv = 1'b0;
      apply();
      // R8: outputs zero while in reset
      for (int c = 0; c < 3; c++) begin
         @(negedge clk);
         compare('0);
      end
      rst_n = 1'b1;

      // R1, R2, R7: single pair sweep over bend, window and offset, all slots
      for (int w = 0; w < 8; w++)
         for (int o = -3; o <= 3; o++)
            for (int d = -10; d <= 10; d++) begin
               clear();
               n_win = w; n_ofs = o;
               n_pv[(d + 10) % NP] = 1'b1;
               n_pp[(d + 10) % NP] = 100;
               n_pr[(d + 10) % NP] = (w + d + 16) % 16;
               n_sv[(o + 3) % NS]  = 1'b1;
               n_sp[(o + 3) % NS]  = 100 + d;
               tick();
            end

      // R1: position edges 0 and 255
      clear(); n_win = 3;
      n_pv = 8'b0000_0011; n_pp[0] = 0; n_pp[1] = 255;
      n_sv = 4'b0011; n_sp[0] = 3; n_sp[1] = 252;
      tick();
      clear(); n_win = 7;
      n_pv[0] = 1'b1; n_pp[0] = 0; n_sv[0] = 1'b1; n_sp[0] = 255;
      tick();

      // R4: masked slots with matching positions give nothing
      clear(); n_win = 7; n_pv = 8'h00; n_sv = 4'hF;
      for (int i = 0; i < NP; i++) n_pp[i] = 50;
      for (int j = 0; j < NS; j++) n_sp[j] = 50;
      tick();
      clear(); n_win = 7; n_pv = 8'hFF; n_sv = 4'h0;
      for (int i = 0; i < NP; i++) n_pp[i] = 50;
      for (int j = 0; j < NS; j++) n_sp[j] = 50;
      tick();

      // R3: nearest strip and tie resolved to lower strip slot
      clear(); n_win = 3; n_pv[0] = 1'b1; n_pp[0] = 50;
      n_sv = 4'hF; n_sp[0] = 53; n_sp[1] = 48; n_sp[2] = 52; n_sp[3] = 47;
      tick();

      // R6: exactly MX matches (no flag), then all NP match (flag)
      clear(); n_win = 1; n_sv[0] = 1'b1; n_sp[0] = 80;
      for (int i = 0; i < MX; i++) begin n_pv[i+2] = 1'b1; n_pp[i+2] = 80; n_pr[i+2] = i; end
      tick();
      clear(); n_win = 1; n_sv[0] = 1'b1; n_sp[0] = 80;
      n_pv = 8'hFF;
      for (int i = 0; i < NP; i++) begin n_pp[i] = 79 + (i % 3); n_pr[i] = 15 - i; end
      tick();

      // R7: idle crossing with matching data yields nothing
      clear(); n_iv = 1'b0; n_win = 7; n_pv = 8'hFF; n_sv = 4'hF;
      tick();

      // R3, R5, R6, R7: random streaming crossings with clustered positions
      for (int c = 0; c < 4000; c++) begin
         clear();
         n_iv  = ($urandom % 8) != 0;
         n_win = $urandom % 8;
         n_ofs = int'($urandom % 9) - 4;
         n_pv  = NP'($urandom);
         n_sv  = NS'($urandom);
         for (int i = 0; i < NP; i++) begin
            n_pp[i] = 60 + int'($urandom % 24);
            n_pr[i] = int'($urandom % 16);
         end
         for (int j = 0; j < NS; j++) n_sp[j] = 60 + int'($urandom % 24);
         tick();
      end

      clear(); n_iv = 1'b0;
      tick();
      tick();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule